// File: doc/BRIEF.md
# PCM Channel Level Meter

The block watches one of several PCM sample lanes and reports how loud that lane is. On every frame strobe (one per 125 µs PCM frame) it takes the sample of the selected lane and converts it to an unsigned magnitude. The sample is read either as 16-bit two's complement or as an 8-bit sign-magnitude code. An 8-bit window register sets how many frames form one measurement. Over that window the block keeps the largest magnitude it has seen. When the window closes, that peak goes into a 16-bit result, which the host reads as a low byte and a high byte. A window length of zero turns windowing off: each sample goes straight to the result.

Bit 0 of the low byte is a ready flag and the magnitude sits above it. Reading the low byte leaves the flag alone. Reading the high byte clears it. So a host that reads low first and high second always gets two halves of the same result. While the flag is set, the result holds its value and any newer result is discarded. A change of lane, of format or of window length restarts the current window, and so does turning the meter off.

Top module: `pcm_level_meter`

## Requirements
- R1: While `meter_en` is 0, strobes are ignored and the result bytes do not change. Disabling the meter also discards the partial window, so the first window after re-enabling holds only samples taken after re-enabling.
- R2: After reset both `res_lo` and `res_hi` read 00h.
- R3: With `win_count` = N (1 to 255), the N-th accepted strobe of a window completes it. The result becomes the largest magnitude among those N samples, and the next window starts its peak from zero.
- R4: The result word is {`res_hi`, `res_lo`}, with the magnitude in bits 15:1 and the ready flag in bit 0. The flag becomes 1 when a result is written. A `rd_hi` pulse clears it; a `rd_lo` pulse does not.
- R5: With `comp_mode` = 0, the lane sample is 16-bit two's complement and its magnitude is its absolute value, except that -32768 gives 32767. With `comp_mode` = 1, only bits 7:0 of the lane are used, as sign (bit 7) and magnitude (bits 6:0), and the magnitude is bits 6:0.
- R6: While the ready flag is 1, the result does not change and any result that completes is dropped.
- R7: With `win_count` = 0, each accepted strobe writes the magnitude of its sample directly into the result if the ready flag is clear.
- R8: `ch_sel` = k selects lane k, taken from bits [16k+15:16k] of `smp_bus`.
- R9: In a cycle where `ch_sel`, `comp_mode` or `win_count` differs from its value in the previous cycle, the window in progress is discarded and a strobe in that same cycle is ignored.
- R10: If `rd_hi` arrives in the same cycle as a window completion while the ready flag is set, the completion is dropped, the flag clears and the stored magnitude is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_strobe | input | 1 | One-cycle pulse per PCM frame; samples valid |
| smp_bus | input | 64 | Four 16-bit lane samples, lane k at bits [16k+15:16k] |
| ch_sel | input | 2 | Lane to measure |
| comp_mode | input | 1 | 0 = linear two's complement, 1 = 8-bit sign-magnitude code |
| meter_en | input | 1 | Meter on/off |
| win_count | input | 8 | Window length in frames; 0 = direct write |
| rd_lo | input | 1 | Host read pulse for the low result byte |
| rd_hi | input | 1 | Host read pulse for the high result byte; clears ready |
| res_lo | output | 8 | Result bits 7:0 (bit 0 = ready) |
| res_hi | output | 8 | Result bits 15:8 |

## Verification
The hardest cases to reach are the collisions. One is a window that closes in the very cycle the host reads the high byte while an older result is still pending. The other is a strobe that arrives in the cycle a configuration field changes. The stimulus leaves a result unread and then closes the next window with a strobe that shares its cycle with `rd_hi`. In a second case it changes the lane on the same clock as a full-scale strobe, and then checks which samples the next result was built from. Windows are also completed while ready is set, and a window is cut short by turning the meter off, so that discarded peaks would show up in the result if they leaked.

// File: rtl/pcm_lvm_pkg.sv
package pcm_lvm_pkg;

   typedef enum logic {
      FMT_LINEAR     = 1'b0,
      FMT_COMPRESSED = 1'b1
   } lvm_fmt_e;

   localparam int unsigned LVM_BYTE_W = 8;

endpackage

// File: rtl/pcm_lvm_mag.sv
module pcm_lvm_mag
   import pcm_lvm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned SMP_W  = 16,
   parameter int unsigned CODE_W = 8,
   parameter int unsigned SEL_W  = $clog2(NUM_CH),
   parameter int unsigned MAG_W  = SMP_W - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*SMP_W-1:0]  smp_bus,
   input  logic [SEL_W-1:0]         ch_sel,
   input  lvm_fmt_e                 fmt,
   output logic [MAG_W-1:0]         mag
);

   localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};
   localparam int unsigned      CMAG_W   = CODE_W - 1;

   logic [SMP_W-1:0] lane [NUM_CH];
   logic [SMP_W-1:0] pick;
   logic [SMP_W-1:0] negated;
   logic [MAG_W-1:0] lin_mag;
   logic [MAG_W-1:0] cmp_mag;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_lane
         assign lane[gi] = smp_bus[gi*SMP_W +: SMP_W];
      end
   endgenerate

   assign pick    = lane[ch_sel];
   assign negated = ~pick + SMP_W'(1);

   always_comb begin
      if (pick == MOST_NEG) begin
         lin_mag = {MAG_W{1'b1}};
      end else if (pick[SMP_W-1]) begin
         lin_mag = negated[MAG_W-1:0];
      end else begin
         lin_mag = pick[MAG_W-1:0];
      end
   end

   assign cmp_mag = {{(MAG_W-CMAG_W){1'b0}}, pick[CMAG_W-1:0]};
   assign mag     = (fmt == FMT_COMPRESSED) ? cmp_mag : lin_mag;

   AST_CMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == FMT_COMPRESSED) |-> (mag[MAG_W-1:CMAG_W] == '0)); // R5

endmodule

// File: rtl/pcm_lvm_window.sv
module pcm_lvm_window #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned MAG_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              strobe,
   input  logic [CNT_W-1:0]  win_n,
   input  logic [MAG_W-1:0]  mag,
   output logic              done,
   output logic [MAG_W-1:0]  value
);

   logic [CNT_W-1:0] cnt_q;
   logic [MAG_W-1:0] peak_q;
   logic [MAG_W-1:0] cand;
   logic             take;
   logic             direct;
   logic             last;

   assign take   = en && !clr && strobe;
   assign direct = (win_n == '0);
   assign last   = !direct && (cnt_q == win_n - CNT_W'(1));
   assign cand   = (mag > peak_q) ? mag : peak_q;
   assign done   = take && (direct || last);
   assign value  = direct ? mag : cand;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         peak_q <= '0;
      end else if (!en || clr) begin
         cnt_q  <= '0;
         peak_q <= '0;
      end else if (take) begin
         if (direct || last) begin
            cnt_q  <= '0;
            peak_q <= '0;
         end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            peak_q <= cand;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |-> (direct ? (cnt_q == '0) : (cnt_q < win_n))); // R3

   AST_PEAK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !direct && !last) |=> (peak_q >= $past(peak_q))); // R3

   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0 && peak_q == '0)); // R1

   AST_CHG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0 && peak_q == '0)); // R9

endmodule

// File: rtl/pcm_lvm_result.sv
module pcm_lvm_result
   import pcm_lvm_pkg::*;
#(
   parameter int unsigned MAG_W = 15,
   parameter int unsigned RES_W = MAG_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [MAG_W-1:0]      load_val,
   input  logic                  rd_lo,
   input  logic                  rd_hi,
   output logic [LVM_BYTE_W-1:0] res_lo,
   output logic [LVM_BYTE_W-1:0] res_hi
);

   logic             ready_q;
   logic [MAG_W-1:0] val_q;
   logic             accept;
   logic [RES_W-1:0] word;

   assign accept = load && !ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         val_q   <= '0;
      end else if (accept) begin
         ready_q <= 1'b1;
         val_q   <= load_val;
      end else if (rd_hi) begin
         ready_q <= 1'b0;
      end
   end

   assign word   = {val_q, ready_q};
   assign res_lo = word[LVM_BYTE_W-1:0];
   assign res_hi = word[RES_W-1:LVM_BYTE_W];

   AST_HI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && ready_q) |=> !ready_q); // R10

   AST_LO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !rd_hi && ready_q) |=> ready_q); // R4

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> $stable(val_q)); // R6

   AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ready_q) |=> (ready_q && val_q == $past(load_val))); // R7

endmodule

// File: rtl/pcm_level_meter.sv
module pcm_level_meter
   import pcm_lvm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned SMP_W  = 16,
   parameter int unsigned CODE_W = 8,
   parameter int unsigned CNT_W  = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         smp_strobe,
   input  logic [NUM_CH*SMP_W-1:0]      smp_bus,
   input  logic [$clog2(NUM_CH)-1:0]    ch_sel,
   input  logic                         comp_mode,
   input  logic                         meter_en,
   input  logic [CNT_W-1:0]             win_count,
   input  logic                         rd_lo,
   input  logic                         rd_hi,
   output logic [LVM_BYTE_W-1:0]        res_lo,
   output logic [LVM_BYTE_W-1:0]        res_hi
);

   localparam int unsigned SEL_W = $clog2(NUM_CH);
   localparam int unsigned MAG_W = SMP_W - 1;
   localparam int unsigned CFG_W = SEL_W + 1 + CNT_W;

   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("NUM_CH must be a power of two, at least 2");
      end
      if (SMP_W != 2 * LVM_BYTE_W) begin : g_bad_smp
         $error("SMP_W must fill exactly two result bytes");
      end
      if (CODE_W < 2 || CODE_W > SMP_W) begin : g_bad_code
         $error("CODE_W out of range");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;
   logic             cfg_chg;
   logic [MAG_W-1:0] mag;
   logic             win_done;
   logic [MAG_W-1:0] win_val;
   lvm_fmt_e         fmt;

   assign fmt     = lvm_fmt_e'(comp_mode);
   assign cfg_now = {ch_sel, comp_mode, win_count};
   assign cfg_chg = (cfg_now != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         cfg_q <= cfg_now;
      end
   end

   pcm_lvm_mag #(
      .NUM_CH (NUM_CH),
      .SMP_W  (SMP_W),
      .CODE_W (CODE_W),
      .SEL_W  (SEL_W),
      .MAG_W  (MAG_W)
   ) u_mag (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_bus (smp_bus),
      .ch_sel  (ch_sel),
      .fmt     (fmt),
      .mag     (mag)
   );

   pcm_lvm_window #(
      .CNT_W (CNT_W),
      .MAG_W (MAG_W)
   ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (meter_en),
      .clr    (cfg_chg),
      .strobe (smp_strobe),
      .win_n  (win_count),
      .mag    (mag),
      .done   (win_done),
      .value  (win_val)
   );

   pcm_lvm_result #(
      .MAG_W (MAG_W)
   ) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (win_done),
      .load_val (win_val),
      .rd_lo    (rd_lo),
      .rd_hi    (rd_hi),
      .res_lo   (res_lo),
      .res_hi   (res_hi)
   );

   AST_OFF_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!meter_en && res_lo[0] == 1'b0) |=> (res_lo[0] == 1'b0)); // R1

   AST_CHG_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_chg && res_lo[0] == 1'b0 && !rd_hi) |=> (res_lo[0] == 1'b0)); // R9

endmodule

// File: tb/tb_pcm_level_meter.sv
module tb_pcm_level_meter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_strobe = 1'b0;
   logic [63:0] smp_bus = '0;
   logic [1:0]  ch_sel = '0;
   logic        comp_mode = 1'b0;
   logic        meter_en = 1'b0;
   logic [7:0]  win_count = '0;
   logic        rd_lo = 1'b0;
   logic        rd_hi = 1'b0;
   logic [7:0]  res_lo;
   logic [7:0]  res_hi;

   int          n_checks = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;
   logic [15:0] exp_q[$];
   logic [15:0] win_vals[$];
   bit          prev_rdy = 1'b0;

   always #2.5 clk = ~clk;

   pcm_level_meter dut (
      .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .smp_bus(smp_bus),
      .ch_sel(ch_sel), .comp_mode(comp_mode), .meter_en(meter_en),
      .win_count(win_count), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .res_lo(res_lo), .res_hi(res_hi)
   );

   function automatic logic [14:0] tb_mag(input logic [15:0] s, input bit comp);
      if (comp) return {8'h00, s[6:0]};
      if (s == 16'h8000) return 15'h7FFF;
      if (s[15]) return 15'(16'(0) - s);
      return s[14:0];
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (res_lo[0] && !prev_rdy) begin
            if (exp_q.size() == 0) begin
               check("R4 unexpected result", {res_hi, res_lo}, 16'h0000);
            end else begin
               check("R3 scoreboard", {res_hi, res_lo}, exp_q.pop_front());
            end
         end
         prev_rdy = res_lo[0];
      end
   end

   task automatic set_bus(input int ch, input logic [15:0] v, input logic [15:0] other);
      for (int k = 0; k < 4; k++) smp_bus[k*16 +: 16] = (k == ch) ? v : other;
   endtask

   task automatic pulse(input int ch, input logic [15:0] v, input logic [15:0] other);
      @(negedge clk);
      set_bus(ch, v, other);
      smp_strobe = 1'b1;
      @(negedge clk);
      smp_strobe = 1'b0;
   endtask

   task automatic set_cfg(input bit en, input int ch, input bit comp, input int n);
      @(negedge clk);
      meter_en  = en;
      ch_sel    = 2'(ch);
      comp_mode = comp;
      win_count = 8'(n);
      @(negedge clk);
   endtask

   task automatic read_lo();
      @(negedge clk); rd_lo = 1'b1;
      @(negedge clk); rd_lo = 1'b0;
   endtask

   task automatic read_hi();
      @(negedge clk); rd_hi = 1'b1;
      @(negedge clk); rd_hi = 1'b0;
   endtask

   task automatic run_win(input int ch, input logic [15:0] other, input bit accept);
      logic [14:0] pk;
      pk = '0;
      for (int i = 0; i < win_vals.size(); i++) begin
         if (tb_mag(win_vals[i], comp_mode) > pk) pk = tb_mag(win_vals[i], comp_mode);
         if (i == win_vals.size() - 1 && accept) exp_q.push_back({pk, 1'b1});
         pulse(ch, win_vals[i], other);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 reset value", {res_hi, res_lo}, 16'h0000);

      // R1: disabled meter ignores strobes
      pulse(0, 16'h1234, 16'h1234);
      check("R1 disabled ignores strobe", {res_hi, res_lo}, 16'h0000);

      // R7: direct mode
      set_cfg(1, 0, 0, 0);
      win_vals = {16'h1234};
      run_win(0, 16'h0000, 1);
      check("R7 direct write", {res_hi, res_lo}, 16'h2469);
      pulse(0, 16'h0100, 16'h0000);
      check("R6 direct drop while ready", {res_hi, res_lo}, 16'h2469);
      read_lo();
      check("R4 low read keeps ready", {15'h0, res_lo[0]}, 16'h0001);
      read_hi();
      check("R4 high read clears ready", {res_hi, res_lo}, 16'h2468);

      // R8, R3, R5: window of 4 on lane 2 with most-negative sample
      set_cfg(1, 2, 0, 4);
      win_vals = {16'hFED4, 16'h0064, 16'h8000, 16'h0005};
      run_win(2, 16'h0000, 1);
      check("R5 saturated magnitude", {res_hi, res_lo}, 16'hFFFF);
      read_hi();
      win_vals = {16'h0010, 16'hFFF0, 16'h0003, 16'h0020};
      run_win(2, 16'h7000, 1);
      check("R8 lane select", {res_hi, res_lo}, 16'h0041);
      read_hi();

      // R5: compressed format, upper bits of lane ignored
      set_cfg(1, 1, 1, 3);
      win_vals = {16'hAB85, 16'h557F, 16'hFFC0};
      run_win(1, 16'h7F7F, 1);
      check("R5 compressed peak", {res_hi, res_lo}, 16'h00FF);
      read_hi();

      // R9: config change aborts window, strobe in change cycle ignored
      set_cfg(1, 3, 0, 4);
      pulse(3, 16'h7000, 16'h7000);
      pulse(3, 16'h7000, 16'h7000);
      @(negedge clk);
      ch_sel = 2'd0;
      set_bus(0, 16'h7FFF, 16'h7FFF);
      smp_strobe = 1'b1;
      @(negedge clk);
      smp_strobe = 1'b0;
      check("R9 no result after abort", {15'h0, res_lo[0]}, 16'h0000);
      win_vals = {16'h0040, 16'h0040, 16'h0040};
      run_win(0, 16'h0000, 0);
      check("R9 change strobe not counted", {15'h0, res_lo[0]}, 16'h0000);
      win_vals = {16'h0040};
      run_win(0, 16'h0000, 1);
      check("R9 window restarted", {res_hi, res_lo}, 16'h0081);
      read_hi();

      // R1: disabling discards partial window
      set_cfg(1, 0, 0, 3);
      pulse(0, 16'h6000, 16'h0000);
      pulse(0, 16'h6000, 16'h0000);
      @(negedge clk); meter_en = 1'b0;
      pulse(0, 16'h6000, 16'h0000);
      @(negedge clk); meter_en = 1'b1;
      win_vals = {16'h0011, 16'h0011, 16'h0011};
      run_win(0, 16'h0000, 1);
      check("R1 partial window discarded", {res_hi, res_lo}, 16'h0023);
      read_hi();

      // R10: completion collides with high read while ready
      set_cfg(1, 0, 0, 2);
      win_vals = {16'h0100, 16'h0002};
      run_win(0, 16'h0000, 1);
      pulse(0, 16'h0300, 16'h0000);
      @(negedge clk);
      set_bus(0, 16'h0400, 16'h0000);
      smp_strobe = 1'b1;
      rd_hi = 1'b1;
      @(negedge clk);
      smp_strobe = 1'b0;
      rd_hi = 1'b0;
      check("R10 collision drops result", {res_hi, res_lo}, 16'h0200);
      win_vals = {16'h0005, 16'h0006};
      run_win(0, 16'h0000, 1);
      check("R10 next window accepted", {res_hi, res_lo}, 16'h000D);
      read_hi();

      // R6: window result dropped while ready
      win_vals = {16'h0001, 16'h0002};
      run_win(0, 16'h0000, 1);
      win_vals = {16'h0050, 16'h0060};
      run_win(0, 16'h0000, 0);
      check("R6 window drop while ready", {res_hi, res_lo}, 16'h0005);
      read_hi();
      win_vals = {16'h0003, 16'h0004};
      run_win(0, 16'h0000, 1);
      check("R6 accepted after read", {res_hi, res_lo}, 16'h0009);
      read_hi();

      // R3: boundary window lengths
      set_cfg(1, 0, 0, 1);
      win_vals = {16'h0009};
      run_win(0, 16'h0000, 1);
      check("R3 window of one", {res_hi, res_lo}, 16'h0013);
      read_hi();
      set_cfg(1, 0, 0, 255);
      for (int i = 0; i < 254; i++) pulse(0, 16'h0001, 16'h0000);
      check("R3 window of 255 not early", {15'h0, res_lo[0]}, 16'h0000);
      win_vals = {16'h1000};
      run_win(0, 16'h0000, 1);
      check("R3 window of 255", {res_hi, res_lo}, 16'h2001);
      read_hi();

      repeat (3) @(negedge clk);
      check("R3 scoreboard drained", 16'(exp_q.size()), 16'h0000);
      finish_run();
   end

endmodule